// File: doc/BRIEF.md
# Banked Double-Buffered 3D Colour Lookup Store

This block holds a three-dimensional colour lookup lattice and, for each incoming pixel, delivers all eight vertices of the sub-cube that contains the pixel, together and in one cycle. The upper bits of the red, green and blue components pick the lattice cell. The lower bits are not used for addressing. They travel alongside the vertex data, so that a downstream interpolator receives the weights in step with the corners. The valid, start-of-frame and end-of-line markers are delayed by the same amount. The block holds no notion of line length or frame height.

The lattice has one more point per axis than there are cells, so the top edge of the colour range has its own vertices. Every lattice point lives in one of eight banks, chosen by the parity of its three coordinates. Any sub-cube therefore touches each bank exactly once, and the eight reads run in parallel. With double buffering enabled each bank holds two pages. A configuration port writes single vertices into either page and requests which page the pixel path reads. The request is applied only when a start-of-frame pixel enters, so no frame ever mixes two tables.

Top module: `cube_lut_store`

## Requirements
- R1: A pixel accepted with `in_valid` high at a rising edge appears on `out_valid` two rising edges later. `out_sof` and `out_eol` carry that pixel's markers in the same output cycle.
- R2: `out_frac_r/g/b` equal the low `COMP_W-MSB_W` bits of the pixel's `in_r/g/b` (bits [3:0] by default) in the same output cycle.
- R3: With n_r, n_g, n_b the upper `MSB_W` bits of each component, corner index c = 4a+2b+d sits at `out_corners[c*30 +: 30]` and holds lattice entry (n_r+a, n_g+b, n_b+d) of the page in use.
- R4: A component at its maximum value (cell index 15) returns vertices from lattice index 16 for its upper corners.
- R5: A vertex write (`cfg_we`=1, `cfg_ctrl`=0) stores `cfg_data` at lattice entry (`cfg_i`,`cfg_j`,`cfg_k`) of page `cfg_page`, and later reads of that entry return it. Indices above 16 are dropped.
- R6: Writing a vertex in one page leaves the same entry of the other page unchanged.
- R7: A page request (`cfg_we`=1, `cfg_ctrl`=1, page in `cfg_page`) changes no pixel until the next pixel accepted with `in_sof` high. That pixel and every later pixel read the requested page.
- R8: After reset `out_valid`, `out_sof` and `out_eol` are low and page 0 is in use.
- R9: Idle input cycles produce idle output cycles. Every accepted pixel produces exactly one output, whatever the line or frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of a line |
| in_r | input | COMP_W | Red component |
| in_g | input | COMP_W | Green component |
| in_b | input | COMP_W | Blue component |
| cfg_we | input | 1 | Configuration access strobe |
| cfg_ctrl | input | 1 | 1: page request, 0: vertex write |
| cfg_page | input | 1 | Target page, or requested page |
| cfg_i | input | MSB_W+1 | Red lattice index of the vertex |
| cfg_j | input | MSB_W+1 | Green lattice index of the vertex |
| cfg_k | input | MSB_W+1 | Blue lattice index of the vertex |
| cfg_data | input | 3*CH_W | Vertex value, 10 bits per channel by default |
| out_valid | output | 1 | Vertices and fractions valid |
| out_sof | output | 1 | Delayed start-of-frame marker |
| out_eol | output | 1 | Delayed end-of-line marker |
| out_frac_r | output | COMP_W-MSB_W | Red low bits |
| out_frac_g | output | COMP_W-MSB_W | Green low bits |
| out_frac_b | output | COMP_W-MSB_W | Blue low bits |
| out_corners | output | 8*3*CH_W | Eight sub-cube vertices, corner 0 in the low bits |

## Verification
A fault in the bank-parity address split or in the corner reorder shows as a wrong vertex on the first output whose cell index is odd on some axis. That is two cycles after such a pixel enters. A wrong page register can show in two ways. One is a table switch inside a frame, seen on the next pixel after the request. The other is a missing switch at the following start-of-frame pixel. Every loaded vertex is a distinct function of page and coordinates, so either fault is seen at once. A misaligned marker or fraction pipe breaks the match against the queued pixel on the first output.

// File: rtl/cube_lut_pkg.sv
// Package cube_lut_pkg
// Shared constants and the lattice-to-bank address arithmetic used by
// both the pixel read path and the configuration write path.
// Assumes each bank reserves a full (half-lattice + 1)^3 block per page.
package cube_lut_pkg;

    localparam int N_BANK = 8;

    // In-bank linear address of a half-lattice triple inside a page
    function automatic int unsigned lat_addr(
        input int unsigned hr,
        input int unsigned hg,
        input int unsigned hb,
        input int unsigned half,
        input int unsigned page,
        input int unsigned page_d
    );
        return page * page_d + (hr * half + hg) * half + hb;
    endfunction

endpackage

// File: rtl/cube_lut_page_ctl.sv
// Module cube_lut_page_ctl
// Holds the requested page and the page in use. The page in use follows
// the request only when a start-of-frame pixel is accepted; that pixel
// already reads the new page. With DOUBLE_BUF = 0 page 0 is always used.
module cube_lut_page_ctl #(
    parameter bit DOUBLE_BUF = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    input  logic cfg_we,
    input  logic cfg_ctrl,
    input  logic cfg_page,
    output logic eff_page
);

    logic pend_q;
    logic act_q;
    logic frame_start;

    assign frame_start = in_valid && in_sof;

    // Latch the most recent page request from the configuration port
    always_ff @(posedge clk) begin
        if (!rst_n)                  pend_q <= 1'b0;
        else if (cfg_we && cfg_ctrl) pend_q <= cfg_page;
    end

    // Adopt the requested page at the first pixel of a frame
    always_ff @(posedge clk) begin
        if (!rst_n)           act_q <= 1'b0;
        else if (frame_start) act_q <= pend_q;
    end

    // Page seen by the address generator this cycle
    always_comb begin
        if (!DOUBLE_BUF)      eff_page = 1'b0;
        else if (frame_start) eff_page = pend_q;
        else                  eff_page = act_q;
    end

    // R7: the page in use never moves except after a frame-start pixel
    p_flip_at_sof_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> $past(in_valid && in_sof));

endmodule

// File: rtl/cube_lut_addr_gen.sv
// Module cube_lut_addr_gen
// First pipeline stage. Splits each component into a cell index and a
// fraction, and forms one read address per parity bank. Along an axis the
// corner at cell n uses the bank whose parity equals n[0]; the corner n+1
// uses the other one. Markers and fractions are registered alongside.
module cube_lut_addr_gen #(
    parameter int COMP_W = 8,
    parameter int MSB_W  = 4,
    parameter int AW     = 11,
    parameter int HALF   = 9,
    parameter int PAGE_D = 729
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         in_valid,
    input  logic                                         in_sof,
    input  logic                                         in_eol,
    input  logic [COMP_W-1:0]                            in_r,
    input  logic [COMP_W-1:0]                            in_g,
    input  logic [COMP_W-1:0]                            in_b,
    input  logic                                         eff_page,
    output logic                                         s1_valid,
    output logic                                         s1_sof,
    output logic                                         s1_eol,
    output logic [COMP_W-MSB_W-1:0]                      s1_frac_r,
    output logic [COMP_W-MSB_W-1:0]                      s1_frac_g,
    output logic [COMP_W-MSB_W-1:0]                      s1_frac_b,
    output logic [2:0]                                   s1_par,
    output logic [cube_lut_pkg::N_BANK-1:0][AW-1:0]      s1_addr
);

    localparam int FRAC_W = COMP_W - MSB_W;
    localparam int IDX_W  = MSB_W + 1;

    logic [MSB_W-1:0] nr, ng, nb;

    assign nr = in_r[COMP_W-1 -: MSB_W];
    assign ng = in_g[COMP_W-1 -: MSB_W];
    assign nb = in_b[COMP_W-1 -: MSB_W];

    // Register markers; valid is cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sof   <= 1'b0;
            s1_eol   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_sof   <= in_sof;
            s1_eol   <= in_eol;
        end
    end

    // Register fractions and cell parities for the later stages
    always_ff @(posedge clk) begin
        s1_frac_r <= in_r[FRAC_W-1:0];
        s1_frac_g <= in_g[FRAC_W-1:0];
        s1_frac_b <= in_b[FRAC_W-1:0];
        s1_par    <= {nr[0], ng[0], nb[0]};
    end

    for (genvar b = 0; b < cube_lut_pkg::N_BANK; b++) begin : g_bank
        localparam logic PR = 1'((b >> 2) & 1);
        localparam logic PG = 1'((b >> 1) & 1);
        localparam logic PB = 1'(b & 1);

        logic [IDX_W-1:0] cr, cg, cb;

        // Lattice coordinate this bank serves for the current cell
        always_comb begin
            cr = {1'b0, nr} + {{(IDX_W-1){1'b0}}, nr[0] ^ PR};
            cg = {1'b0, ng} + {{(IDX_W-1){1'b0}}, ng[0] ^ PG};
            cb = {1'b0, nb} + {{(IDX_W-1){1'b0}}, nb[0] ^ PB};
        end

        // Register the bank read address, page offset included
        always_ff @(posedge clk) begin
            s1_addr[b] <= AW'(cube_lut_pkg::lat_addr(
                32'(cr[IDX_W-1:1]), 32'(cg[IDX_W-1:1]), 32'(cb[IDX_W-1:1]),
                HALF, 32'(eff_page), PAGE_D));
        end
    end

endmodule

// File: rtl/cube_lut_bank.sv
// Module cube_lut_bank
// One parity bank: a simple dual-port memory with one write and one
// registered read per cycle. A read of the address being written returns
// the old content. Contents are not reset.
module cube_lut_bank #(
    parameter int DW    = 30,
    parameter int DEPTH = 1458,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Store one vertex when the write strobe is set
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read of the addressed vertex
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

    // R5: the write decoder never targets a slot outside the bank
    p_wr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/cube_lut_corner_sel.sv
// Module cube_lut_corner_sel
// Second pipeline stage. Registers markers and fractions in step with the
// bank read data, then places bank outputs into fixed corner order: corner
// c is held by bank c XOR the cell parity triple.
module cube_lut_corner_sel #(
    parameter int FRAC_W = 4,
    parameter int DW     = 30
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     s1_valid,
    input  logic                                     s1_sof,
    input  logic                                     s1_eol,
    input  logic [FRAC_W-1:0]                        s1_frac_r,
    input  logic [FRAC_W-1:0]                        s1_frac_g,
    input  logic [FRAC_W-1:0]                        s1_frac_b,
    input  logic [2:0]                               s1_par,
    input  logic [cube_lut_pkg::N_BANK-1:0][DW-1:0]  bank_rd,
    output logic                                     out_valid,
    output logic                                     out_sof,
    output logic                                     out_eol,
    output logic [FRAC_W-1:0]                        out_frac_r,
    output logic [FRAC_W-1:0]                        out_frac_g,
    output logic [FRAC_W-1:0]                        out_frac_b,
    output logic [cube_lut_pkg::N_BANK*DW-1:0]       out_corners
);

    logic [2:0] s2_par;

    // Delay markers by the bank read stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            out_sof   <= s1_sof;
            out_eol   <= s1_eol;
        end
    end

    // Delay fractions and parity by the bank read stage
    always_ff @(posedge clk) begin
        out_frac_r <= s1_frac_r;
        out_frac_g <= s1_frac_g;
        out_frac_b <= s1_frac_b;
        s2_par     <= s1_par;
    end

    for (genvar c = 0; c < cube_lut_pkg::N_BANK; c++) begin : g_corner
        // Route the bank that holds this corner
        assign out_corners[c*DW +: DW] = bank_rd[3'(c) ^ s2_par];
    end

endmodule

// File: rtl/cube_lut_store.sv
// Module cube_lut_store
// Top of the banked lattice store. Pixel path: address generation, eight
// parity banks, corner reorder; fixed two-cycle latency. Configuration
// path: single-vertex writes into either page, and page requests applied
// at the next frame-start pixel. Assumes markers arrive only with valid.
module cube_lut_store #(
    parameter int COMP_W     = 8,
    parameter int MSB_W      = 4,
    parameter int CH_W       = 10,
    parameter bit DOUBLE_BUF = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sof,
    input  logic                       in_eol,
    input  logic [COMP_W-1:0]          in_r,
    input  logic [COMP_W-1:0]          in_g,
    input  logic [COMP_W-1:0]          in_b,
    input  logic                       cfg_we,
    input  logic                       cfg_ctrl,
    input  logic                       cfg_page,
    input  logic [MSB_W:0]             cfg_i,
    input  logic [MSB_W:0]             cfg_j,
    input  logic [MSB_W:0]             cfg_k,
    input  logic [3*CH_W-1:0]          cfg_data,
    output logic                       out_valid,
    output logic                       out_sof,
    output logic                       out_eol,
    output logic [COMP_W-MSB_W-1:0]    out_frac_r,
    output logic [COMP_W-MSB_W-1:0]    out_frac_g,
    output logic [COMP_W-MSB_W-1:0]    out_frac_b,
    output logic [8*3*CH_W-1:0]        out_corners
);

    import cube_lut_pkg::*;

    localparam int FRAC_W = COMP_W - MSB_W;
    localparam int IDX_W  = MSB_W + 1;
    localparam int N_IDX  = (1 << MSB_W) + 1;
    localparam int HALF   = (1 << (MSB_W - 1)) + 1;
    localparam int PAGE_D = HALF * HALF * HALF;
    localparam int PAGES  = DOUBLE_BUF ? 2 : 1;
    localparam int DEPTH  = PAGES * PAGE_D;
    localparam int AW     = $clog2(DEPTH);
    localparam int VTX_W  = 3 * CH_W;

    logic                          eff_page;
    logic                          s1_valid, s1_sof, s1_eol;
    logic [FRAC_W-1:0]             s1_frac_r, s1_frac_g, s1_frac_b;
    logic [2:0]                    s1_par;
    logic [N_BANK-1:0][AW-1:0]     s1_addr;
    logic [N_BANK-1:0][VTX_W-1:0]  bank_rd;

    logic                          wr_ok;
    logic [2:0]                    wr_bank;
    logic [AW-1:0]                 wr_addr;
    logic                          wr_page;

    cube_lut_page_ctl #(.DOUBLE_BUF(DOUBLE_BUF)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .cfg_we   (cfg_we),
        .cfg_ctrl (cfg_ctrl),
        .cfg_page (cfg_page),
        .eff_page (eff_page)
    );

    cube_lut_addr_gen #(
        .COMP_W (COMP_W),
        .MSB_W  (MSB_W),
        .AW     (AW),
        .HALF   (HALF),
        .PAGE_D (PAGE_D)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eol    (in_eol),
        .in_r      (in_r),
        .in_g      (in_g),
        .in_b      (in_b),
        .eff_page  (eff_page),
        .s1_valid  (s1_valid),
        .s1_sof    (s1_sof),
        .s1_eol    (s1_eol),
        .s1_frac_r (s1_frac_r),
        .s1_frac_g (s1_frac_g),
        .s1_frac_b (s1_frac_b),
        .s1_par    (s1_par),
        .s1_addr   (s1_addr)
    );

    // Decode a vertex write into a bank, an address and an enable
    always_comb begin
        wr_page = DOUBLE_BUF ? cfg_page : 1'b0;
        wr_bank = {cfg_i[0], cfg_j[0], cfg_k[0]};
        wr_ok   = cfg_we && !cfg_ctrl
                  && (int'(cfg_i) < N_IDX) && (int'(cfg_j) < N_IDX) && (int'(cfg_k) < N_IDX)
                  && (DOUBLE_BUF || !cfg_page);
        wr_addr = AW'(lat_addr(32'(cfg_i[IDX_W-1:1]), 32'(cfg_j[IDX_W-1:1]),
                               32'(cfg_k[IDX_W-1:1]), HALF, 32'(wr_page), PAGE_D));
    end

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        cube_lut_bank #(.DW(VTX_W), .DEPTH(DEPTH), .AW(AW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_ok && (wr_bank == 3'(b))),
            .waddr (wr_addr),
            .wdata (cfg_data),
            .raddr (s1_addr[b]),
            .rdata (bank_rd[b])
        );
    end

    cube_lut_corner_sel #(.FRAC_W(FRAC_W), .DW(VTX_W)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .s1_valid    (s1_valid),
        .s1_sof      (s1_sof),
        .s1_eol      (s1_eol),
        .s1_frac_r   (s1_frac_r),
        .s1_frac_g   (s1_frac_g),
        .s1_frac_b   (s1_frac_b),
        .s1_par      (s1_par),
        .bank_rd     (bank_rd),
        .out_valid   (out_valid),
        .out_sof     (out_sof),
        .out_eol     (out_eol),
        .out_frac_r  (out_frac_r),
        .out_frac_g  (out_frac_g),
        .out_frac_b  (out_frac_b),
        .out_corners (out_corners)
    );

    // R1: an accepted pixel shows up exactly two cycles later
    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R9: an idle input cycle yields an idle output cycle
    p_idle_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R1: end-of-line marker follows its pixel
    p_eol_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eol) |-> ##2 (out_valid && out_eol));

    // R2: red fraction arrives unchanged with its pixel
    p_frac_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (out_frac_r == $past(in_r[FRAC_W-1:0], 2)));

endmodule

// File: tb/cube_lut_store_tb.sv
module cube_lut_store_tb;

    localparam int COMP_W = 8;
    localparam int MSB_W  = 4;
    localparam int FRAC_W = 4;
    localparam int CH_W   = 10;
    localparam int VTX_W  = 30;
    localparam int NI     = 17;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [COMP_W-1:0]       in_r = '0, in_g = '0, in_b = '0;
    logic                    cfg_we = 1'b0, cfg_ctrl = 1'b0, cfg_page = 1'b0;
    logic [MSB_W:0]          cfg_i = '0, cfg_j = '0, cfg_k = '0;
    logic [VTX_W-1:0]        cfg_data = '0;
    logic                    out_valid, out_sof, out_eol;
    logic [FRAC_W-1:0]       out_frac_r, out_frac_g, out_frac_b;
    logic [8*VTX_W-1:0]      out_corners;

    cube_lut_store u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl), .cfg_page(cfg_page),
        .cfg_i(cfg_i), .cfg_j(cfg_j), .cfg_k(cfg_k), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
        .out_frac_r(out_frac_r), .out_frac_g(out_frac_g), .out_frac_b(out_frac_b),
        .out_corners(out_corners)
    );

    int     n_chk = 0;
    int     n_fail = 0;
    longint cyc = 0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [8*VTX_W-1:0]  crn;
        logic                sof;
        logic                eol;
        logic [3*FRAC_W-1:0] frac;
        longint              t;
        string               req;
    } exp_t;

    exp_t q[$];

    // bench-side page model and one overridden vertex
    bit             m_pend = 1'b0, m_act = 1'b0;
    bit             ov_on = 1'b0;
    int             ov_p, ov_i, ov_j, ov_k;
    logic [VTX_W-1:0] ov_val;

    function automatic logic [VTX_W-1:0] vf(int p, int i, int j, int k);
        if (ov_on && p == ov_p && i == ov_i && j == ov_j && k == ov_k) return ov_val;
        return {10'(p * 512 + i * 17 + j), 10'(j * 29 + k * 3 + p), 10'(k * 31 + i)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] a, input logic [255:0] e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, a, e);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // driver: one pixel for one cycle, expected item queued
    task automatic push_px(input int r, input int g, input int b,
                           input bit sof, input bit eol, input string req);
        exp_t e;
        int   pg;
        @(posedge clk); #1;
        cfg_we   = 1'b0;
        in_valid = 1'b1; in_sof = sof; in_eol = eol;
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        if (sof) m_act = m_pend;
        pg = m_act;
        for (int c = 0; c < 8; c++)
            e.crn[c*VTX_W +: VTX_W] = vf(pg, (r >> 4) + ((c >> 2) & 1),
                                         (g >> 4) + ((c >> 1) & 1), (b >> 4) + (c & 1));
        e.sof  = sof;
        e.eol  = eol;
        e.frac = {4'(r), 4'(g), 4'(b)};
        e.t    = cyc;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; cfg_we = 1'b0;
        end
    endtask

    task automatic cfg_vtx(input int p, input int i, input int j, input int k,
                           input logic [VTX_W-1:0] v);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        cfg_we = 1'b1; cfg_ctrl = 1'b0; cfg_page = 1'(p);
        cfg_i = 5'(i); cfg_j = 5'(j); cfg_k = 5'(k); cfg_data = v;
    endtask

    task automatic cfg_sel(input int p);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        cfg_we = 1'b1; cfg_ctrl = 1'b1; cfg_page = 1'(p);
        m_pend = 1'(p);
    endtask

    // monitor: compare each output against the queue head
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done && out_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R9", "output with no pixel queued", 256'(1), 256'(0));
            end else begin
                e = q.pop_front();
                chk(out_corners == e.crn, e.req, "corners", 256'(out_corners), 256'(e.crn));
                chk((cyc - e.t) == 2, "R1", "latency", 256'(cyc - e.t), 256'(2));
                chk({out_sof, out_eol} == {e.sof, e.eol}, "R1", "sof/eol",
                    256'({out_sof, out_eol}), 256'({e.sof, e.eol}));
                chk({out_frac_r, out_frac_g, out_frac_b} == e.frac, "R2", "fractions",
                    256'({out_frac_r, out_frac_g, out_frac_b}), 256'(e.frac));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1'b1;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({out_valid, out_sof, out_eol} == 3'b000, "R8", "outputs in reset",
            256'({out_valid, out_sof, out_eol}), 256'(0));
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({out_valid, out_sof, out_eol} == 3'b000, "R8", "outputs after reset",
            256'({out_valid, out_sof, out_eol}), 256'(0));

        // load both pages with distinct values
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < NI; i++)
                for (int j = 0; j < NI; j++)
                    for (int k = 0; k < NI; k++)
                        cfg_vtx(p, i, j, k, vf(p, i, j, k));
        idle(2);

        // R8: first frame with no request reads page 0; R3 mixed parities
        push_px(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R8");
        push_px(8'h13, 8'h2A, 8'h7F, 1'b0, 1'b0, "R3");
        push_px(8'hA5, 8'h5A, 8'h3C, 1'b0, 1'b1, "R3");
        idle(3);
        push_px(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, "R4");
        push_px(8'hF0, 8'h0F, 8'hE7, 1'b0, 1'b1, "R4");
        idle(1);

        // R7: request page 1 mid-frame; pixels keep page 0 until sof
        cfg_sel(1);
        push_px(8'h91, 8'h62, 8'h33, 1'b0, 1'b0, "R7");
        idle(2);
        push_px(8'h44, 8'h55, 8'h66, 1'b0, 1'b1, "R7");
        push_px(8'h44, 8'h55, 8'h66, 1'b1, 1'b0, "R7");
        push_px(8'hFF, 8'h80, 8'h01, 1'b0, 1'b1, "R7");
        idle(2);

        // R6: rewrite a page-0 vertex while page 1 is read
        ov_on = 1'b1; ov_p = 0; ov_i = 16; ov_j = 16; ov_k = 16; ov_val = 30'h2AAA_5555;
        cfg_vtx(0, 16, 16, 16, ov_val);
        push_px(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, "R6");
        // R5: out-of-range index is dropped (value never observed)
        cfg_vtx(0, 17, 0, 0, 30'h3FFF_FFFF);
        push_px(8'h0F, 8'h0F, 8'h0F, 1'b0, 1'b1, "R6");

        // R5: back to page 0 at next frame; new vertex visible
        cfg_sel(0);
        push_px(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, "R5");
        push_px(8'hF8, 8'hF1, 8'hFE, 1'b0, 1'b1, "R5");
        push_px(8'h10, 8'h00, 8'h00, 1'b0, 1'b0, "R5");

        // R9: frames of other sizes back to back
        push_px(8'h01, 8'h02, 8'h03, 1'b1, 1'b1, "R9");
        push_px(8'h7E, 8'h81, 8'hC3, 1'b1, 1'b0, "R9");
        push_px(8'h3D, 8'hD3, 8'h99, 1'b0, 1'b0, "R9");
        push_px(8'hEE, 8'h11, 8'h77, 1'b0, 1'b1, "R9");
        idle(6);

        chk(q.size() == 0, "R9", "pixels without output", 256'(q.size()), 256'(0));
        done = 1'b1;
        summary();
        $finish;
    end

endmodule